// File: doc/BRIEF.md
# Pulse-coded isolation channel codec

This block carries one logic level across a link that can only pass short pulses. The transmit half samples the data input through a two-flop synchronizer. It turns every level change into a single-cycle pulse: a `set` pulse for a rising change and a `clear` pulse for a falling one. When the input stays quiet, the transmit half repeats the present level as a refresh pulse at a fixed cycle interval. A receiver that missed a pulse therefore recovers the correct level at DC.

The receive half is a set/clear latch fed by those pulses. A watchdog counts cycles without a valid pulse. When the count reaches its limit, the watchdog forces the output to a configured default level, on the assumption that the sending side has lost power. The two halves share one top module, but the link lines are brought out. A chip wires `tx_*` to `rx_*` across the barrier model, and a test can cut the link or inject faults.

Top module: `pulse_iso_codec`

## Requirements
- R1: A rising change on `din` gives exactly one `tx_set` pulse, and a falling change gives exactly one `tx_clr` pulse. The pulse is visible after the third rising clock edge that follows the change (two synchronizer stages plus a registered output).
- R2: On the clock edge that samples `rx_set` high with `rx_clr` low, `dout` becomes 1. On the edge that samples `rx_clr` high with `rx_set` low, `dout` becomes 0. Between pulses `dout` holds its value.
- R3: While the synchronized input does not change, a refresh pulse matching its level (`tx_set` for 1, `tx_clr` for 0) is emitted every `REFRESH_CYCLES` cycles. The count restarts after every real edge pulse and after every refresh pulse.
- R4: If `WATCHDOG_CYCLES` rising edges pass with no valid received pulse, `dout` equals `DEFAULT_LEVEL` after the last of those edges and stays there until a valid pulse arrives.
- R5: With `tx_*` looped to `rx_*` and an idle input, the watchdog never fires. This holds because `WATCHDOG_CYCLES` is larger than `REFRESH_CYCLES`.
- R6: While `rst` is high, `tx_set` and `tx_clr` are 0 and `dout` equals `DEFAULT_LEVEL`. The first edge after `rst` falls emits a refresh pulse of the synchronized level, which is low out of reset.
- R7: The first valid pulse after a watchdog timeout loads its own level into `dout` on the next edge.
- R8: Every transmit pulse lasts one cycle, and `tx_set` and `tx_clr` are never high in the same cycle.
- R9: A cycle with `rx_set` and `rx_clr` both high is ignored: `dout` keeps its value and the watchdog count is not restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Asynchronous data level to transmit |
| tx_set | output | 1 | Transmit pulse: level went (or is) high |
| tx_clr | output | 1 | Transmit pulse: level went (or is) low |
| rx_set | input | 1 | Received set pulse from the link |
| rx_clr | input | 1 | Received clear pulse from the link |
| dout | output | 1 | Recovered data level |

## Verification
The watchdog boundary is the hardest case to reach from the ports. In a healthy loop, refresh pulses keep restarting the count, so it never expires. The bench therefore breaks the loop and drives `rx_set`/`rx_clr` itself: one lone pulse, then silence, with `dout` sampled on the edge before and the edge at which the count runs out. The same injection path places a conflicting pulse pair two cycles before expiry. This shows that the pair neither moves the output nor rescues the count.

// File: rtl/iso_codec_pkg.sv
package iso_codec_pkg;

    typedef struct packed {
        logic set;
        logic clr;
    } pulse_pair_t;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_SET  = 2'd1,
        PK_CLR  = 2'd2,
        PK_BAD  = 2'd3
    } pulse_kind_e;

    localparam pulse_pair_t NO_PULSE = '{set: 1'b0, clr: 1'b0};

    function automatic pulse_kind_e classify(input pulse_pair_t p);
        case ({p.set, p.clr})
            2'b10:   return PK_SET;
            2'b01:   return PK_CLR;
            2'b11:   return PK_BAD;
            default: return PK_NONE;
        endcase
    endfunction

    function automatic pulse_pair_t level_pulse(input logic lvl);
        pulse_pair_t p;
        p.set = lvl;
        p.clr = ~lvl;
        return p;
    endfunction

endpackage

// File: rtl/iso_sync.sv
module iso_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/iso_encoder.sv
module iso_encoder
    import iso_codec_pkg::*;
#(
    parameter int REFRESH_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lvl,
    output pulse_pair_t tx
);
    localparam int CW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

    logic          prev_lvl;
    logic          boot;
    logic [CW-1:0] idle_cnt;
    pulse_pair_t   tx_q;
    logic          changed;
    logic          due;

    assign changed = lvl ^ prev_lvl;
    assign due     = boot || (idle_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= 1'b0;
            boot     <= 1'b1;
            idle_cnt <= '0;
            tx_q     <= NO_PULSE;
        end else begin
            prev_lvl <= lvl;
            if (changed || due) begin
                tx_q     <= level_pulse(lvl);
                idle_cnt <= '0;
                boot     <= 1'b0;
            end else begin
                tx_q     <= NO_PULSE;
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    assign tx = tx_q;
endmodule

// File: rtl/iso_decoder.sv
module iso_decoder
    import iso_codec_pkg::*;
#(
    parameter int   WATCHDOG_CYCLES = 80,
    parameter logic DEFAULT_LEVEL   = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  pulse_pair_t rx,
    output logic        dout
);
    localparam int WW = (WATCHDOG_CYCLES > 2) ? $clog2(WATCHDOG_CYCLES) : 1;
    localparam logic [WW-1:0] LAST = WW'(WATCHDOG_CYCLES - 1);

    pulse_kind_e   kind;
    logic [WW-1:0] quiet_cnt;
    logic          level_q;

    assign kind = classify(rx);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= DEFAULT_LEVEL;
            quiet_cnt <= '0;
        end else begin
            case (kind)
                PK_SET: begin
                    level_q   <= 1'b1;
                    quiet_cnt <= '0;
                end
                PK_CLR: begin
                    level_q   <= 1'b0;
                    quiet_cnt <= '0;
                end
                default: begin
                    if (quiet_cnt == LAST) level_q   <= DEFAULT_LEVEL;
                    else                   quiet_cnt <= quiet_cnt + 1'b1;
                end
            endcase
        end
    end

    assign dout = level_q;
endmodule

// File: rtl/pulse_iso_codec.sv
module pulse_iso_codec
    import iso_codec_pkg::*;
#(
    parameter int   SYNC_STAGES     = 2,
    parameter int   REFRESH_CYCLES  = 16,
    parameter int   WATCHDOG_CYCLES = 80,
    parameter logic DEFAULT_LEVEL   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic tx_set,
    output logic tx_clr,
    input  logic rx_set,
    input  logic rx_clr,
    output logic dout
);
    logic        din_sync;
    pulse_pair_t tx_p;
    pulse_pair_t rx_p;

    iso_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (din_sync)
    );

    iso_encoder #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_enc (
        .clk (clk),
        .rst (rst),
        .lvl (din_sync),
        .tx  (tx_p)
    );

    assign tx_set = tx_p.set;
    assign tx_clr = tx_p.clr;
    assign rx_p   = '{set: rx_set, clr: rx_clr};

    iso_decoder #(
        .WATCHDOG_CYCLES (WATCHDOG_CYCLES),
        .DEFAULT_LEVEL   (DEFAULT_LEVEL)
    ) u_dec (
        .clk  (clk),
        .rst  (rst),
        .rx   (rx_p),
        .dout (dout)
    );
endmodule

// File: rtl/iso_codec_checker.sv
module iso_codec_checker #(
    parameter int   REFRESH_CYCLES  = 16,
    parameter int   WATCHDOG_CYCLES = 80,
    parameter logic DEFAULT_LEVEL   = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic tx_set,
    input logic tx_clr,
    input logic rx_set,
    input logic rx_clr,
    input logic dout
);
    localparam int GW = $clog2(REFRESH_CYCLES + 1);
    localparam int IW = $clog2(WATCHDOG_CYCLES + 1);

    logic [GW-1:0] gap_cnt;
    logic [IW-1:0] idle_cnt;
    logic          rx_valid;

    assign rx_valid = rx_set ^ rx_clr;

    initial begin
        assert_window_order_R5: assert (WATCHDOG_CYCLES > REFRESH_CYCLES);
        assert_refresh_min_R8: assert (REFRESH_CYCLES >= 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt  <= '0;
            idle_cnt <= '0;
        end else begin
            if (tx_set || tx_clr)                  gap_cnt <= '0;
            else if (gap_cnt != GW'(REFRESH_CYCLES)) gap_cnt <= gap_cnt + 1'b1;
            if (rx_valid)                             idle_cnt <= '0;
            else if (idle_cnt != IW'(WATCHDOG_CYCLES)) idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assert_tx_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(tx_set && tx_clr));
    assert_set_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        tx_set |=> !tx_set);
    assert_clr_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        tx_clr |=> !tx_clr);
    assert_refresh_gap_R3: assert property (@(posedge clk) disable iff (rst)
        gap_cnt < GW'(REFRESH_CYCLES));
    assert_set_latches_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_set && !rx_clr) |=> dout);
    assert_clr_latches_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_clr && !rx_set) |=> !dout);
    assert_watchdog_default_R4: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt == IW'(WATCHDOG_CYCLES)) |-> (dout == DEFAULT_LEVEL));
    assert_conflict_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_set && rx_clr) |=> (dout == $past(dout) || dout == DEFAULT_LEVEL));
    assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
        (!rx_set && !rx_clr && idle_cnt < IW'(WATCHDOG_CYCLES - 1)) |=> $stable(dout));
endmodule

bind pulse_iso_codec iso_codec_checker #(
    .REFRESH_CYCLES  (REFRESH_CYCLES),
    .WATCHDOG_CYCLES (WATCHDOG_CYCLES),
    .DEFAULT_LEVEL   (DEFAULT_LEVEL)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tx_set (tx_set),
    .tx_clr (tx_clr),
    .rx_set (rx_set),
    .rx_clr (rx_clr),
    .dout   (dout)
);

// File: tb/sim_pulse_iso_codec.sv
`timescale 1ns/1ps
module sim_pulse_iso_codec;
    localparam int   REF = 16;
    localparam int   WD  = 80;
    localparam logic DEF = 1'b0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic loop_en = 1'b1;
    logic inj_set = 1'b0;
    logic inj_clr = 1'b0;
    logic tx_set, tx_clr, dout;
    logic rx_set, rx_clr;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int overlap_cnt = 0;
    int double_cnt  = 0;
    logic prev_set = 1'b0;
    logic prev_clr = 1'b0;

    assign rx_set = loop_en ? tx_set : inj_set;
    assign rx_clr = loop_en ? tx_clr : inj_clr;

    always #5 clk = ~clk;

    pulse_iso_codec #(
        .SYNC_STAGES     (2),
        .REFRESH_CYCLES  (REF),
        .WATCHDOG_CYCLES (WD),
        .DEFAULT_LEVEL   (DEF)
    ) u0 (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .tx_set (tx_set),
        .tx_clr (tx_clr),
        .rx_set (rx_set),
        .rx_clr (rx_clr),
        .dout   (dout)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog-timeout (all) actual=%0d expected<=150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_set && tx_clr) overlap_cnt++;
            if ((tx_set && prev_set) || (tx_clr && prev_clr)) double_cnt++;
        end
        prev_set = tx_set;
        prev_clr = tx_clr;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dout == DEF, "R6 dout in reset", dout, DEF);
        check(!tx_set && !tx_clr, "R6 tx idle in reset", {tx_set, tx_clr}, 0);
        rst = 1'b0;
        step();
        check(tx_clr && !tx_set, "R6 boot refresh is clear", {tx_set, tx_clr}, 1);
        step();
        check(!dout && !tx_set && !tx_clr, "R6 quiet after boot", {dout, tx_set, tx_clr}, 0);
    endtask

    // drive a level change and follow it cycle by cycle (loopback on)
    task automatic test_edge(input logic v);
        din = v;
        for (int k = 1; k <= 4; k++) begin
            step();
            check(tx_set == ((k == 3) && v), "R1 set pulse timing", tx_set, (k == 3) && v);
            check(tx_clr == ((k == 3) && !v), "R1 clr pulse timing", tx_clr, (k == 3) && !v);
        end
        check(dout == v, "R2 latch follows pulse", dout, v);
    endtask

    task automatic test_refresh(input logic v);
        int bad = 0;
        test_edge(v);
        for (int c = 2; c <= 2 * REF; c++) begin
            step();
            if (tx_set != ((c % REF == 0) && v))  bad++;
            if (tx_clr != ((c % REF == 0) && !v)) bad++;
        end
        check(bad == 0, "R3 refresh cadence and level", bad, 0);
        check(dout == v, "R3 level held by refresh", dout, v);
    endtask

    task automatic test_healthy();
        int drops = 0;
        test_edge(1'b1);
        for (int c = 0; c < 3 * WD; c++) begin
            step();
            if (dout != 1'b1) drops++;
        end
        check(drops == 0, "R5 healthy idle link keeps level", drops, 0);
    endtask

    task automatic inject(input logic s, input logic c);
        inj_set = s;
        inj_clr = c;
        step();
        inj_set = 1'b0;
        inj_clr = 1'b0;
    endtask

    task automatic test_watchdog();
        int early = 0;
        loop_en = 1'b0;
        inject(1'b1, 1'b0);
        check(dout == 1'b1, "R2 injected set", dout, 1);
        for (int c = 1; c < WD; c++) begin
            step();
            if (dout != 1'b1) early++;
        end
        check(early == 0, "R4 no early timeout", early, 0);
        step();
        check(dout == DEF, "R4 timeout to default", dout, DEF);
        repeat (5) step();
        check(dout == DEF, "R4 default held", dout, DEF);
    endtask

    task automatic test_recover();
        inject(1'b1, 1'b0);
        check(dout == 1'b1, "R7 first pulse after timeout loads", dout, 1);
        repeat (3) step();
        check(dout == 1'b1, "R2 holds between pulses", dout, 1);
        inject(1'b0, 1'b1);
        check(dout == 1'b0, "R2 clear pulse", dout, 0);
    endtask

    task automatic test_conflict();
        inject(1'b1, 1'b0);
        repeat (WD - 3) step();
        inject(1'b1, 1'b1);
        check(dout == 1'b1, "R9 conflict leaves output", dout, 1);
        step();
        check(dout == 1'b1, "R9 before expiry", dout, 1);
        step();
        check(dout == DEF, "R9 conflict did not restart watchdog", dout, DEF);
    endtask

    initial begin
        test_reset();
        test_edge(1'b1);
        test_edge(1'b0);
        test_refresh(1'b1);
        test_refresh(1'b0);
        test_healthy();
        test_watchdog();
        test_recover();
        test_conflict();
        check(overlap_cnt == 0, "R8 no set and clear together", overlap_cnt, 0);
        check(double_cnt == 0, "R8 pulses are one cycle", double_cnt, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule